// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt sources for a small 8-bit processor core and presents the winning one to the core as a fixed vector address. The five sources are two active-low external pins, two timer overflow pulses and a serial port. The serial port requests service while its transmit-done flag or its receive-full flag is high. Each source has its own enable bit, and one global enable bit gates all five. A priority bit per source places it in the high or the low level.

The core sees `vec_valid` together with a 16-bit `vec_addr`. It takes the request by pulsing `ack` for one cycle while `vec_valid` is high. It ends a handler by pulsing `reti`. The controller records which levels are in service. A high-level request can therefore interrupt a running low-level handler. A request of equal or lower level waits until the active handler returns.

Edge-latched external flags and timer flags clear automatically when the core accepts them. Level-triggered pins and the serial flags belong to the requesting logic and are not cleared here.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The vector address is 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1 and 0x0023 for serial, which is base 0x0003 plus 8 times the source index in that order.
- R2: In `en_reg`, bit 0 enables external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, and bit 7 is a global enable; a source is offered only when both its bit and bit 7 are 1. A latched request whose enable is off stays pending and is offered once it is enabled.
- R3: `ext_edge[i]`=0 makes external i request while its pin is low; `ext_edge[i]`=1 makes it latch a request on a high-to-low transition of the pin.
- R4: The serial source requests while `ser_tx_done` or `ser_rx_full` is 1.
- R5: `prio_reg` bit i (same bit order as R2) set to 1 puts source i in the high level; an enabled high-level request wins over every low-level one.
- R6: Among requests of one level, the winner is the first in the order external 0, timer 0, external 1, timer 1, serial.
- R7: A high-level request is offered while only a low-level handler is in service, and its acceptance marks the high level in service; `svc_lvl` bit 1 means high in service, bit 0 low in service.
- R8: While a high-level handler is in service no request is offered; while a low-level handler is in service low-level requests are held back until `reti`.
- R9: A `reti` pulse clears the high in-service bit if it is set, otherwise the low in-service bit.
- R10: Accepting a request clears the latched edge flag or timer flag of that source; a level-mode external request and the serial request remain asserted after acceptance.
- R11: After synchronous reset `vec_valid`=0, `vec_addr`=0, `svc_lvl`=0, and all latched flags are clear.
- R12: `vec_valid` is 0 in the cycle after an `ack` taken while it was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_reg | input | 8 | Per-source enables (bits 0..4) and global enable (bit 7) |
| prio_reg | input | 5 | Per-source high-priority select |
| ext_pin_n | input | 2 | External request pins, active low, asynchronous |
| ext_edge | input | 2 | Per-pin trigger mode: 0 low level, 1 falling edge |
| tmr_ovf | input | 2 | Timer 0 / timer 1 overflow pulses |
| ser_tx_done | input | 1 | Serial transmit-complete flag |
| ser_rx_full | input | 1 | Serial receive-full flag |
| ack | input | 1 | Core accepts the offered vector |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_valid | output | 1 | A vector is offered |
| vec_addr | output | 16 | Offered vector address |
| svc_lvl | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The bench aims at the nesting rules. A second low-level request arrives during a low handler, a second high-level request during a high handler, and a high-level request during a low handler. A controller that preempts at equal level would offer a vector too early. One that blocks on any activity would never offer the high vector. It also retires two nested levels in turn, so that a `reti` that clears the wrong bit shows up as a wrong `svc_lvl`.

Auto-clear is checked per source kind. A timer or edge source re-offered after its return means a missing clear. A level pin or serial source that is not re-offered means a wrongful clear. Further runs cover a request pended under a disabled enable and then released, and a fully loaded request set with and without priority bits, which catches a wrong fixed order.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Source indices in fixed arbitration order; index also selects the vector slot.
  localparam int N_EXT   = 2;
  localparam int N_TMR   = 2;
  localparam int NUM_SRC = N_EXT + N_TMR + 1;
  localparam int SRC_IW  = $clog2(NUM_SRC);
  localparam int SER_IDX = NUM_SRC - 1;

  typedef enum logic [SRC_IW-1:0] {
    SRC_XI0 = 3'd0,
    SRC_TM0 = 3'd1,
    SRC_XI1 = 3'd2,
    SRC_TM1 = 3'd3,
    SRC_SER = 3'd4
  } src_e;

  // External pin i sits at slot 2*i, timer i at slot 2*i+1.
  function automatic int ext_slot(input int i);
    return 2 * i;
  endfunction

  function automatic int tmr_slot(input int i);
    return 2 * i + 1;
  endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  // Resets to the idle (high) level of an active-low pin.
  logic [STAGES-1:0] shf;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) shf <= '1;
        else     shf <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) shf <= '1;
        else     shf <= {shf[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = shf[STAGES-1];

endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
  parameter int N_EXT       = 2,
  parameter int N_TMR       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] ext_pin_n,
  input  logic [N_EXT-1:0] ext_edge,
  input  logic [N_TMR-1:0] tmr_ovf,
  input  logic [N_EXT-1:0] clr_ext,
  input  logic [N_TMR-1:0] clr_tmr,
  output logic [N_EXT-1:0] ext_req,
  output logic [N_TMR-1:0] tmr_req
);

  genvar g;

  generate
    for (g = 0; g < N_EXT; g++) begin : g_ext
      logic pin_s;
      logic pin_prev;
      logic fall_flag;

      irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_pin_n[g]),
        .q   (pin_s)
      );

      // A new falling edge wins over a clear in the same cycle.
      always_ff @(posedge clk) begin
        if (rst) begin
          pin_prev  <= 1'b1;
          fall_flag <= 1'b0;
        end else begin
          pin_prev <= pin_s;
          if (!ext_edge[g])             fall_flag <= 1'b0;
          else if (pin_prev && !pin_s)  fall_flag <= 1'b1;
          else if (clr_ext[g])          fall_flag <= 1'b0;
        end
      end

      assign ext_req[g] = ext_edge[g] ? fall_flag : ~pin_s;
    end

    for (g = 0; g < N_TMR; g++) begin : g_tmr
      logic ovf_flag;

      always_ff @(posedge clk) begin
        if (rst)              ovf_flag <= 1'b0;
        else if (tmr_ovf[g])  ovf_flag <= 1'b1;
        else if (clr_tmr[g])  ovf_flag <= 1'b0;
      end

      assign tmr_req[g] = ovf_flag;
    end
  endgenerate

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);

  // Lowest index wins: scan downward so the last match is the lowest.
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic svc_hi,
  output logic svc_lo
);

  logic nxt_hi;
  logic nxt_lo;

  always_comb begin
    nxt_hi = svc_hi;
    nxt_lo = svc_lo;
    if (reti) begin
      if (svc_hi) nxt_hi = 1'b0;
      else        nxt_lo = 1'b0;
    end
    if (take) begin
      if (take_hi) nxt_hi = 1'b1;
      else         nxt_lo = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_hi <= 1'b0;
      svc_lo <= 1'b0;
    end else begin
      svc_hi <= nxt_hi;
      svc_lo <= nxt_lo;
    end
  end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16,
  parameter int VEC_BASE    = 3,
  parameter int VEC_STRIDE  = 8,
  parameter int GLOBAL_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        en_reg,
  input  logic [4:0]        prio_reg,
  input  logic [1:0]        ext_pin_n,
  input  logic [1:0]        ext_edge,
  input  logic [1:0]        tmr_ovf,
  input  logic              ser_tx_done,
  input  logic              ser_rx_full,
  input  logic              ack,
  input  logic              reti,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [1:0]        svc_lvl
);

  logic [N_EXT-1:0]   ext_req;
  logic [N_TMR-1:0]   tmr_req;
  logic [N_EXT-1:0]   clr_ext;
  logic [N_TMR-1:0]   clr_tmr;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] en_mask;
  logic [NUM_SRC-1:0] act_hi;
  logic [NUM_SRC-1:0] act_lo;
  logic               hit_hi;
  logic               hit_lo;
  logic [SRC_IW-1:0]  idx_hi;
  logic [SRC_IW-1:0]  idx_lo;
  logic               win_ok;
  logic               win_hi;
  logic [SRC_IW-1:0]  win_id;
  logic               svc_hi;
  logic               svc_lo;
  logic               take;
  logic [SRC_IW-1:0]  id_q;
  logic               hi_q;
  logic               unused_en;

  assign unused_en = ^en_reg[6:5];

  irq_src_flags #(
    .N_EXT       (N_EXT),
    .N_TMR       (N_TMR),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_flags (
    .clk       (clk),
    .rst       (rst),
    .ext_pin_n (ext_pin_n),
    .ext_edge  (ext_edge),
    .tmr_ovf   (tmr_ovf),
    .clr_ext   (clr_ext),
    .clr_tmr   (clr_tmr),
    .ext_req   (ext_req),
    .tmr_req   (tmr_req)
  );

  // Interleave sources into arbitration order.
  genvar g;
  generate
    for (g = 0; g < N_EXT; g++) begin : g_pend_ext
      assign pend[ext_slot(g)] = ext_req[g];
      assign clr_ext[g]        = take && (id_q == SRC_IW'(ext_slot(g)));
    end
    for (g = 0; g < N_TMR; g++) begin : g_pend_tmr
      assign pend[tmr_slot(g)] = tmr_req[g];
      assign clr_tmr[g]        = take && (id_q == SRC_IW'(tmr_slot(g)));
    end
  endgenerate

  assign pend[SER_IDX] = ser_tx_done | ser_rx_full;

  assign en_mask = en_reg[NUM_SRC-1:0] & {NUM_SRC{en_reg[GLOBAL_BIT]}};
  assign act_hi  = pend & en_mask &  prio_reg;
  assign act_lo  = pend & en_mask & ~prio_reg;

  irq_pick #(.N(NUM_SRC), .IW(SRC_IW)) u_pick_hi (
    .req (act_hi),
    .hit (hit_hi),
    .idx (idx_hi)
  );

  irq_pick #(.N(NUM_SRC), .IW(SRC_IW)) u_pick_lo (
    .req (act_lo),
    .hit (hit_lo),
    .idx (idx_lo)
  );

  // Nesting gate: high level blocks everything, low level blocks low.
  always_comb begin
    win_ok = 1'b0;
    win_hi = 1'b1;
    win_id = idx_hi;
    if (!svc_hi) begin
      if (hit_hi) begin
        win_ok = 1'b1;
      end else if (!svc_lo && hit_lo) begin
        win_ok = 1'b1;
        win_hi = 1'b0;
        win_id = idx_lo;
      end
    end
  end

  assign take = ack & vec_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      id_q      <= '0;
      hi_q      <= 1'b0;
    end else begin
      vec_valid <= win_ok & ~take;
      vec_addr  <= ADDR_W'(VEC_BASE) + ADDR_W'(win_id) * ADDR_W'(VEC_STRIDE);
      id_q      <= win_id;
      hi_q      <= win_hi;
    end
  end

  irq_svc_track u_svc (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .take_hi (hi_q),
    .reti    (reti),
    .svc_hi  (svc_hi),
    .svc_lo  (svc_lo)
  );

  assign svc_lvl = {svc_hi, svc_lo};

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  en_reg,
  input logic        ack,
  input logic        reti,
  input logic        vec_valid,
  input logic [15:0] vec_addr,
  input logic [1:0]  svc_lvl
);

  // R1: an offered vector is one of the five slots
  p_vec_slot_r1: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_addr[2:0] == 3'd3 && vec_addr[15:6] == 10'd0 && vec_addr[5:3] <= 3'd4));

  // R2: nothing offered unless the global enable was set when chosen
  p_global_gate_r2: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(en_reg[7]));

  // R7: acceptance marks some level in service
  p_take_marks_r7: assert property (@(posedge clk) disable iff (rst)
    (ack && vec_valid && !reti) |=> (svc_lvl != 2'b00));

  // R8: high level in service blocks every offer
  p_hi_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    svc_lvl[1] |-> !vec_valid);

  // R9: return pops the high level first
  p_reti_hi_r9: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack && svc_lvl == 2'b11) |=> (svc_lvl == 2'b01));

  // R9: return with only low active clears it
  p_reti_lo_r9: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack && svc_lvl == 2'b01) |=> (svc_lvl == 2'b00));

  // R12: accepted offer is withdrawn next cycle
  p_ack_drop_r12: assert property (@(posedge clk) disable iff (rst)
    (ack && vec_valid) |=> !vec_valid);

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_reg    (en_reg),
  .ack       (ack),
  .reti      (reti),
  .vec_valid (vec_valid),
  .vec_addr  (vec_addr),
  .svc_lvl   (svc_lvl)
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  en_reg = 8'h00;
  logic [4:0]  prio_reg = 5'h00;
  logic [1:0]  ext_pin_n = 2'b11;
  logic [1:0]  ext_edge = 2'b00;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_tx_done = 1'b0;
  logic        ser_rx_full = 1'b0;
  logic        ack = 1'b0;
  logic        reti = 1'b0;
  logic        vec_valid;
  logic [15:0] vec_addr;
  logic [1:0]  svc_lvl;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk         (clk),
    .rst         (rst),
    .en_reg      (en_reg),
    .prio_reg    (prio_reg),
    .ext_pin_n   (ext_pin_n),
    .ext_edge    (ext_edge),
    .tmr_ovf     (tmr_ovf),
    .ser_tx_done (ser_tx_done),
    .ser_rx_full (ser_rx_full),
    .ack         (ack),
    .reti        (reti),
    .vec_valid   (vec_valid),
    .vec_addr    (vec_addr),
    .svc_lvl     (svc_lvl)
  );

  // Row: en(8) prio(5) edge(2) pin_low(2) tmr_pulse(2) ser{rx,tx}(2) exp_valid(1) exp_addr(16)
  typedef struct packed {
    logic [7:0]  en;
    logic [4:0]  pr;
    logic [1:0]  md;
    logic [1:0]  pl;
    logic [1:0]  tp;
    logic [1:0]  sr;
    logic        ev;
    logic [15:0] ea;
  } row_t;

  localparam int NROW = 13;
  localparam logic [37:0] ROWS [NROW] = '{
    {8'h9F, 5'b00000, 2'b00, 2'b00, 2'b01, 2'b00, 1'b1, 16'h000B}, // R1 timer 0
    {8'h1F, 5'b00000, 2'b00, 2'b00, 2'b01, 2'b00, 1'b0, 16'h0000}, // R2 global off
    {8'h9D, 5'b00000, 2'b00, 2'b00, 2'b01, 2'b00, 1'b0, 16'h0000}, // R2 own enable off
    {8'h9F, 5'b00000, 2'b00, 2'b00, 2'b11, 2'b00, 1'b1, 16'h000B}, // R6 t0 over t1
    {8'h9F, 5'b01000, 2'b00, 2'b00, 2'b11, 2'b00, 1'b1, 16'h001B}, // R5 t1 high
    {8'h9F, 5'b00000, 2'b00, 2'b00, 2'b00, 2'b01, 1'b1, 16'h0023}, // R4 tx done
    {8'h9F, 5'b00000, 2'b00, 2'b00, 2'b00, 2'b10, 1'b1, 16'h0023}, // R4 rx full
    {8'h9F, 5'b00000, 2'b00, 2'b01, 2'b00, 2'b00, 1'b1, 16'h0003}, // R3 x0 level
    {8'h9F, 5'b00000, 2'b10, 2'b10, 2'b00, 2'b00, 1'b1, 16'h0013}, // R3 x1 edge
    {8'h9F, 5'b10000, 2'b00, 2'b11, 2'b11, 2'b11, 1'b1, 16'h0023}, // R5 serial high
    {8'h9F, 5'b00000, 2'b00, 2'b11, 2'b11, 2'b11, 1'b1, 16'h0003}, // R6 all low
    {8'h9F, 5'b00000, 2'b00, 2'b10, 2'b10, 2'b00, 1'b1, 16'h0013}, // R6 x1 over t1
    {8'h9F, 5'b00000, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 16'h0000}  // R3 idle pins
  };
  string row_req [NROW] = '{"R1", "R2", "R2", "R6", "R5", "R4", "R4",
                            "R3", "R3", "R5", "R6", "R6", "R3"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ext_pin_n = 2'b11; ext_edge = 2'b00; tmr_ovf = 2'b00;
    ser_tx_done = 1'b0; ser_rx_full = 1'b0; ack = 1'b0; reti = 1'b0;
    wait_n(3);
    rst = 1'b0;
  endtask

  task automatic pulse_tmr(input logic [1:0] m);
    tmr_ovf = m;
    @(negedge clk);
    tmr_ovf = 2'b00;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  initial begin
    do_reset();
    // R11: reset state
    chk("R11 valid", 32'(vec_valid), 32'd0);
    chk("R11 addr", 32'(vec_addr), 32'd0);
    chk("R11 svc", 32'(svc_lvl), 32'd0);

    // Table walk
    for (int i = 0; i < NROW; i++) begin
      row_t r;
      r = row_t'(ROWS[i]);
      do_reset();
      en_reg = r.en; prio_reg = r.pr; ext_edge = r.md;
      ext_pin_n = ~r.pl; ser_tx_done = r.sr[0]; ser_rx_full = r.sr[1];
      pulse_tmr(r.tp);
      wait_n(6);
      chk(row_req[i], 32'(vec_valid), 32'(r.ev));
      if (r.ev) chk(row_req[i], 32'(vec_addr), 32'(r.ea));
    end

    // R11: reset drops a latched timer flag
    do_reset();
    en_reg = 8'h9F; prio_reg = 5'b00000;
    pulse_tmr(2'b01);
    do_reset();
    wait_n(4);
    chk("R11 flag cleared", 32'(vec_valid), 32'd0);

    // R7 / R9: high preempts low, then nested return
    do_reset();
    en_reg = 8'h9F; prio_reg = 5'b01000;
    pulse_tmr(2'b01);
    wait_n(4);
    chk("R7 low offered", 32'(vec_addr), 32'h000B);
    do_ack();
    chk("R12 drop", 32'(vec_valid), 32'd0);
    chk("R7 low svc", 32'(svc_lvl), 32'b01);
    pulse_tmr(2'b10);
    wait_n(4);
    chk("R7 high offered", 32'(vec_valid), 32'd1);
    chk("R7 high addr", 32'(vec_addr), 32'h001B);
    do_ack();
    chk("R7 both svc", 32'(svc_lvl), 32'b11);
    wait_n(3);
    chk("R8 hi blocks", 32'(vec_valid), 32'd0);
    do_reti();
    chk("R9 pop high", 32'(svc_lvl), 32'b01);
    do_reti();
    chk("R9 pop low", 32'(svc_lvl), 32'b00);
    wait_n(3);
    chk("R10 timer cleared", 32'(vec_valid), 32'd0);

    // R8: low does not preempt low
    do_reset();
    en_reg = 8'h9F; prio_reg = 5'b00000;
    pulse_tmr(2'b10);
    wait_n(4);
    do_ack();
    pulse_tmr(2'b01);
    wait_n(4);
    chk("R8 low waits", 32'(vec_valid), 32'd0);
    do_reti();
    wait_n(3);
    chk("R8 low after return", 32'(vec_valid), 32'd1);
    chk("R8 low addr", 32'(vec_addr), 32'h000B);

    // R8: high does not preempt high
    do_reset();
    en_reg = 8'h9F; prio_reg = 5'b01010;
    pulse_tmr(2'b10);
    wait_n(4);
    do_ack();
    pulse_tmr(2'b01);
    wait_n(4);
    chk("R8 high waits", 32'(vec_valid), 32'd0);
    do_reti();
    wait_n(3);
    chk("R8 high after return", 32'(vec_addr), 32'h000B);

    // R10: edge flag cleared on accept, pin held low
    do_reset();
    en_reg = 8'h9F; prio_reg = 5'b00000; ext_edge = 2'b01;
    ext_pin_n = 2'b10;
    wait_n(6);
    chk("R3 edge offered", 32'(vec_addr), 32'h0003);
    do_ack();
    do_reti();
    wait_n(4);
    chk("R10 edge cleared", 32'(vec_valid), 32'd0);

    // R10: level pin stays asserted after accept
    do_reset();
    en_reg = 8'h9F; prio_reg = 5'b00000; ext_edge = 2'b00;
    ext_pin_n = 2'b10;
    wait_n(6);
    do_ack();
    chk("R10 level svc", 32'(svc_lvl), 32'b01);
    do_reti();
    wait_n(3);
    chk("R10 level kept", 32'(vec_valid), 32'd1);
    chk("R10 level addr", 32'(vec_addr), 32'h0003);

    // R10: serial flag stays asserted after accept
    do_reset();
    en_reg = 8'h9F; prio_reg = 5'b00000; ser_rx_full = 1'b1;
    wait_n(4);
    do_ack();
    do_reti();
    wait_n(3);
    chk("R10 serial kept", 32'(vec_addr), 32'h0023);
    chk("R10 serial valid", 32'(vec_valid), 32'd1);

    // R2: disabled request stays pending, released on enable
    do_reset();
    en_reg = 8'h80; prio_reg = 5'b00000;
    pulse_tmr(2'b01);
    wait_n(4);
    chk("R2 held back", 32'(vec_valid), 32'd0);
    en_reg = 8'h82;
    wait_n(3);
    chk("R2 released", 32'(vec_valid), 32'd1);
    chk("R2 released addr", 32'(vec_addr), 32'h000B);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule